// File: doc/BRIEF.md
# Potentiometer wiper register bank

This block holds the register state of a two-channel digitally controlled potentiometer. Each channel owns two 8-bit values that sit at one bus address: a volatile wiper setting that drives the resistor tap, and a non-volatile start-up setting. A control register chooses which of the two a channel access reaches. It also switches both channels into shutdown and reports when a non-volatile store is still busy.

The block is reached over a plain register bus with an address, write data, a write strobe, a read strobe and registered read data. The wiper settings and a shutdown flag leave the block as plain outputs. The non-volatile store is modelled with flops that keep their contents through reset. A programmable down counter stands in for the time a real store takes to program. While that counter runs, the bank accepts no writes. On reset, each wiper takes the stored start-up value of its channel.

Top module: `dpot_regbank`

## Requirements
- R1: Channel i sits at address i (channel 0 at 0x0, channel 1 at 0x1) and the control register sits at 0x8. Reading any other address returns 0x00, and writing one changes no output and no register.
- R2: With control bit 7 at 1, a channel write updates only that channel's wiper output and leaves its stored start-up value unchanged. A channel read returns the wiper value.
- R3: With control bit 7 at 0, a channel write stores the byte as the start-up value and also places it on that channel's wiper output. A channel read returns the stored start-up value.
- R4: A control write takes bit 7 as the target select and bit 6 as the run flag. `shdn_o` is 1 exactly when the run flag is 0. A control read returns {select, run, busy, 5'b00000}, so bits 4..0 always read 0.
- R5: A non-volatile store starts on the clock edge that takes the write. Control reads taken on the following BUSY_CYC edges show bit 5 = 1, and the read on the edge after those shows bit 5 = 0.
- R6: While bit 5 is 1, writes to the channel addresses (in either mode) and to the control register are ignored.
- R7: Synchronous reset sets select to 0 and run to 1, clears busy and sets read data to 0x00. It loads each wiper from that channel's stored start-up value, and it leaves the stored values unchanged.
- R8: `bus_rdata` takes the addressed value on each clock edge where `bus_rd` is 1, and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| wiper_o | output | NUM_CH*8 | Wiper settings, channel i in bits [8i+7:8i] |
| shdn_o | output | 1 | High when both channels are shut down |

## Verification
All 256 byte values are swept through both channels in each mode, and channel 1 always gets a different value than channel 0, so a crossed or shared channel shows up. In start-up mode the sweep separates a store that fails to reach the wiper from one that fails to reach the readback. In wiper mode, reading the stored values back afterwards shows whether a volatile write leaked into the store. Back-to-back control reads after a store measure the busy window to the exact edge. Writes issued inside that window, a reset after the wipers have been changed, and writes to unmapped addresses each test whether state that should stay fixed actually stays fixed.

// File: rtl/dpot_regbank_pkg.sv
package dpot_regbank_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'h8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic sel_vol;
        logic run;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{sel_vol: 1'b0, run: 1'b1};

    function automatic byte_t ctrl_image(input ctrl_t c, input logic busy);
        return {c.sel_vol, c.run, busy, 5'b00000};
    endfunction

    function automatic ctrl_t ctrl_from_byte(input byte_t d);
        ctrl_t c;
        c.sel_vol = d[7];
        c.run     = d[6];
        return c;
    endfunction

endpackage

// File: rtl/dpot_chan.sv
module dpot_chan
    import dpot_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  logic  sel_vol,
    input  logic  busy,
    input  byte_t wdata,
    output byte_t wiper_q,
    output byte_t nv_q,
    output logic  nv_start
);

    logic wp_we;
    logic nv_we;

    always_comb begin
        wp_we = wr_sel && !busy;
        nv_we = wp_we && !sel_vol;
    end

    assign nv_start = nv_we;

    always_ff @(posedge clk) begin
        if (nv_we) begin
            nv_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper_q <= nv_q;
        end else if (wp_we) begin
            wiper_q <= wdata;
        end
    end

    // R3
    nv_write_both_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !busy && !sel_vol) |=> (wiper_q == $past(wdata) && nv_q == $past(wdata)));

    // R2
    vol_keeps_nv_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !busy && sel_vol) |=> ($stable(nv_q) && wiper_q == $past(wdata)));

    // R6
    busy_lock_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && busy) |=> ($stable(wiper_q) && $stable(nv_q)));

    // R7
    reset_reload_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper_q == $past(nv_q)));

endmodule

// File: rtl/dpot_busy.sv
module dpot_busy #(
    parameter int BUSY_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R5
    busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  logic  busy,
    input  byte_t wdata,
    output ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_sel && !busy) begin
            ctrl_q <= ctrl_from_byte(wdata);
        end
    end

    // R6
    busy_lock_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && busy) |=> $stable(ctrl_q));

    // R7
    ctrl_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q.sel_vol == 1'b0 && ctrl_q.run == 1'b1));

endmodule

// File: rtl/dpot_regbank.sv
module dpot_regbank
    import dpot_regbank_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int BUSY_CYC = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH*DATA_W-1:0] wiper_o,
    output logic                     shdn_o
);

    byte_t             wiper_q [NUM_CH];
    byte_t             nv_q    [NUM_CH];
    logic [NUM_CH-1:0] nv_start;
    logic              busy;
    ctrl_t             ctrl_q;
    byte_t             rd_mux;
    logic              ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ch_wr;
        assign ch_wr = bus_wr && (bus_addr == ADDR_W'(i));

        dpot_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (ch_wr),
            .sel_vol  (ctrl_q.sel_vol),
            .busy     (busy),
            .wdata    (bus_wdata),
            .wiper_q  (wiper_q[i]),
            .nv_q     (nv_q[i]),
            .nv_start (nv_start[i])
        );

        assign wiper_o[i*DATA_W +: DATA_W] = wiper_q[i];
    end

    dpot_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (|nv_start),
        .busy  (busy)
    );

    dpot_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (ctrl_wr),
        .busy   (busy),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q)
    );

    assign shdn_o = !ctrl_q.run;

    always_comb begin
        rd_mux = '0;
        if (bus_addr == CTRL_ADDR) begin
            rd_mux = ctrl_image(ctrl_q, busy);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                rd_mux = ctrl_q.sel_vol ? wiper_q[i] : nv_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CTRL_ADDR) |=> (bus_rdata[4:0] == 5'b00000 && bus_rdata[5] == $past(busy)));

    // R6
    one_store_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(nv_start));

endmodule

// File: tb/dpot_regbank_bench.sv
module dpot_regbank_bench;

    localparam int NCH  = 2;
    localparam int BCYC = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_rdata;
    logic [15:0]  wiper_o;
    logic         shdn_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dpot_regbank #(.NUM_CH(NCH), .BUSY_CYC(BCYC)) u_dpot_regbank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .wiper_o   (wiper_o),
        .shdn_o    (shdn_o)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // all tasks start and end at a negedge
    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        repeat (BCYC) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog got=%h exp=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 reset state
        chk("R7 rdata after reset", bus_rdata, 8'h00);
        chk("R7 shdn after reset", {7'b0, shdn_o}, 8'h00);
        do_rd(4'h8, d); chk("R7 ctrl after reset", d, 8'h40);

        // R1 unmapped reads
        do_rd(4'h5, d); chk("R1 read 0x5", d, 8'h00);
        do_rd(4'hF, d); chk("R1 read 0xF", d, 8'h00);

        // R3 start-up mode sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] a0, a1;
            a0 = 8'(v);
            a1 = 8'(v) ^ 8'h5A;
            do_wr(4'h0, a0); chk("R3 wiper0", wiper_o[7:0], a0);
            wait_idle();
            do_wr(4'h1, a1); chk("R3 wiper1", wiper_o[15:8], a1);
            chk("R3 wiper0 kept", wiper_o[7:0], a0);
            wait_idle();
            do_rd(4'h0, d); chk("R3 read ch0", d, a0);
            do_rd(4'h1, d); chk("R3 read ch1", d, a1);
        end

        // R5 busy window
        do_wr(4'h0, 8'h3C);
        for (int j = 1; j <= BCYC + 1; j++) begin
            do_rd(4'h8, d);
            chk("R5 busy bit", {7'b0, d[5]}, (j <= BCYC) ? 8'h01 : 8'h00);
        end

        // R6 writes ignored while busy
        do_wr(4'h1, 8'hA5);
        do_wr(4'h0, 8'h77);
        do_wr(4'h8, 8'h80);
        chk("R6 wiper0 locked", wiper_o[7:0], 8'h3C);
        wait_idle();
        do_rd(4'h0, d); chk("R6 store ch0 locked", d, 8'h3C);
        do_rd(4'h1, d); chk("R6 store ch1 taken", d, 8'hA5);
        do_rd(4'h8, d); chk("R6 ctrl locked", d, 8'h40);

        // R4 control fields
        do_wr(4'h8, 8'hFF);
        do_rd(4'h8, d); chk("R4 ctrl 0xFF", d, 8'hC0);
        chk("R4 shdn run", {7'b0, shdn_o}, 8'h00);
        do_wr(4'h8, 8'h9F);
        chk("R4 shdn off", {7'b0, shdn_o}, 8'h01);
        do_rd(4'h8, d); chk("R4 ctrl 0x9F", d, 8'h80);
        do_wr(4'h8, 8'hC0);
        chk("R4 shdn back", {7'b0, shdn_o}, 8'h00);

        // R2 wiper mode sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b0, b1;
            b0 = 8'(v);
            b1 = ~8'(v);
            do_wr(4'h0, b0);
            do_wr(4'h1, b1);
            chk("R2 wiper0", wiper_o[7:0], b0);
            chk("R2 wiper1", wiper_o[15:8], b1);
            do_rd(4'h0, d); chk("R2 read ch0", d, b0);
            do_rd(4'h1, d); chk("R2 read ch1", d, b1);
        end
        do_rd(4'h8, d); chk("R2 no busy", d, 8'hC0);
        do_wr(4'h8, 8'h40);
        do_rd(4'h0, d); chk("R2 store ch0 kept", d, 8'h3C);
        do_rd(4'h1, d); chk("R2 store ch1 kept", d, 8'hA5);

        // R1 unmapped writes
        do_wr(4'h3, 8'hEE);
        do_wr(4'hC, 8'h00);
        chk("R1 wiper0 unchanged", wiper_o[7:0], 8'hFF);
        chk("R1 wiper1 unchanged", wiper_o[15:8], 8'h00);
        chk("R1 shdn unchanged", {7'b0, shdn_o}, 8'h00);
        do_rd(4'h8, d); chk("R1 ctrl unchanged", d, 8'h40);
        do_rd(4'h0, d); chk("R1 store unchanged", d, 8'h3C);

        // R8 hold without strobe
        bus_addr = 4'h1;
        repeat (2) @(negedge clk);
        chk("R8 rdata held", bus_rdata, 8'h3C);
        do_rd(4'h1, d); chk("R8 rdata updates", d, 8'hA5);

        // R7 reload from store
        do_wr(4'h8, 8'hC0);
        do_wr(4'h0, 8'h11);
        do_wr(4'h1, 8'h22);
        chk("R7 pre wiper0", wiper_o[7:0], 8'h11);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7 reload wiper0", wiper_o[7:0], 8'h3C);
        chk("R7 reload wiper1", wiper_o[15:8], 8'hA5);
        chk("R7 rdata cleared", bus_rdata, 8'h00);
        do_rd(4'h8, d); chk("R7 ctrl reset", d, 8'h40);
        do_rd(4'h0, d); chk("R7 store kept", d, 8'h3C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule